// File: doc/BRIEF.md
# Banked ECC Error Logger

This block gathers uncorrectable memory error events from a set of SRAM banks and holds them for software. Each bank's ECC decoder raises a one-cycle pulse when a read has a 2-bit or wider error and presents the failing address alongside it. Correctable single-bit errors are fixed in the decoder and never reach this block. For each reporting bank the logger sets a sticky flag and captures the failing address. It keeps one flag and one address register per bank.

Two outputs reach the rest of the system. A level-sensitive interrupt stays high while any flag is set. A bus error strobe marks the failing read as errored in the cycle after the decoder reports it. Software reads the flags and the captured addresses through a small register port. It clears flags by writing ones to the status register, and the bank keeps its first captured address until its flag has been cleared.

Top module: `eccFaultLog`

## Requirements
- R1: After reset all flags are clear, `eccIrq` and `busErr` are low, `regRData` is zero, and every address register reads zero.
- R2: A pulse on `bankErr[i]` sets flag i on the next clock. Banks are independent, and several may report in the same cycle. Flags appear at register index 0, bit i = bank i, with all upper bits reading zero.
- R3: A set flag stays set until software clears it, whatever the error inputs do.
- R4: A write to register index 0 clears each flag whose data bit is 1. Data bits that are 0 leave flags untouched. Writes to any other index change no flag and no address register.
- R5: When bank i reports while its flag is clear, the bank's slice `bankAddr[i*AddrW +: AddrW]` is captured. It reads back at register index i+1 in the low AddrW bits, with the upper bits zero.
- R6: While flag i is set and not being cleared, further errors in bank i leave its captured address unchanged.
- R7: If a W1C of flag i and a new error in bank i fall in the same cycle, flag i ends up set and the new error's address is captured.
- R8: `eccIrq` is high exactly while at least one flag is set. It rises on the clock that sets the first flag and falls on the clock that clears the last one.
- R9: `busErr` is high for the one cycle after any cycle with a `bankErr` bit set, and is low otherwise.
- R10: A read (`regRdEn` high) updates `regRData` on the next clock. `regRData` holds its value when no read is made. Indices above the bank count read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankErr | input | NumBanks | Per-bank uncorrectable error pulse |
| bankAddr | input | NumBanks*AddrW | Failing address per bank, bank i in slice i |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | RegAW | Register index: 0 status, i+1 bank i address |
| regWData | input | DataW | Register write data |
| regRData | output | DataW | Registered read data |
| eccIrq | output | 1 | Level interrupt, OR of all flags |
| busErr | output | 1 | Error response for the failing read |

## Verification
A flag that is stuck, lost or set by the wrong bank shows on `eccIrq` on the next clock and in the next status read. The interrupt only reveals the problem when that flag is the sole one set, so the bench reads the status register after every step. A wrong address-capture decision stays hidden until that bank's address register is read, so every step reads all eight address registers against an independent model. The same-cycle clear-and-error case and the repeated-error case are the ones where a capture bug would otherwise go unseen.

// File: rtl/eccLogPkg.sv
package eccLogPkg;

  localparam int LOG_BANKS = 8;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic anyErr;     // at least one bank reported this cycle
    logic rdStrobe;   // register read requested
    logic rdStatus;   // read targets the status register
    logic rdAddrHit;  // read targets a bank address register
  } logStrobes_t;

endpackage

// File: rtl/eccLogCtrl.sv
module eccLogCtrl
  import eccLogPkg::*;
#(
  parameter int NumBanks = LOG_BANKS,
  parameter int RegAW    = 4,
  localparam int BankIdxW = (NumBanks > 1) ? $clog2(NumBanks) : 1
) (
  input  logic [NumBanks-1:0] bankErr,
  input  logic [NumBanks-1:0] statusFlags,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [RegAW-1:0]    regAddr,
  input  logic [NumBanks-1:0] wrBits,
  output logStrobes_t         strobes,
  output logic [NumBanks-1:0] setMask,
  output logic [NumBanks-1:0] clrMask,
  output logic [NumBanks-1:0] loadMask,
  output logic [BankIdxW-1:0] rdBank
);

  localparam logic [RegAW-1:0] LastAddrIdx = RegAW'(NumBanks);

  logic statusHit;

  always_comb begin
    statusHit = (regAddr == '0);
    clrMask   = (regWrEn && statusHit) ? wrBits : '0;
    setMask   = bankErr;
    // capture only the first failure since the last clear
    loadMask  = bankErr & (~statusFlags | clrMask);

    strobes.anyErr    = |bankErr;
    strobes.rdStrobe  = regRdEn;
    strobes.rdStatus  = statusHit;
    strobes.rdAddrHit = !statusHit && (regAddr <= LastAddrIdx);

    rdBank = BankIdxW'(regAddr - RegAW'(1));
  end

endmodule

// File: rtl/eccLogData.sv
module eccLogData
  import eccLogPkg::*;
#(
  parameter int NumBanks = LOG_BANKS,
  parameter int AddrW    = 20,
  parameter int DataW    = 32,
  localparam int BankIdxW = (NumBanks > 1) ? $clog2(NumBanks) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logStrobes_t               strobes,
  input  logic [NumBanks-1:0]       setMask,
  input  logic [NumBanks-1:0]       clrMask,
  input  logic [NumBanks-1:0]       loadMask,
  input  logic [BankIdxW-1:0]       rdBank,
  input  logic [NumBanks*AddrW-1:0] bankAddr,
  output logic [NumBanks-1:0]       statusFlags,
  output logic [NumBanks*AddrW-1:0] addrFlat,
  output logic [DataW-1:0]          regRData,
  output logic                      busErr,
  output logic                      eccIrq
);

  logic [AddrW-1:0] addrReg [NumBanks];
  logic [DataW-1:0] rdMux;

  // sticky flags: a new error outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) statusFlags <= '0;
    else       statusFlags <= (statusFlags & ~clrMask) | setMask;
  end

  for (genvar b = 0; b < NumBanks; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)            addrReg[b] <= '0;
      else if (loadMask[b]) addrReg[b] <= bankAddr[b*AddrW +: AddrW];
    end
    assign addrFlat[b*AddrW +: AddrW] = addrReg[b];
  end

  always_comb begin
    rdMux = '0;
    if (strobes.rdStatus)       rdMux = DataW'(statusFlags);
    else if (strobes.rdAddrHit) rdMux = DataW'(addrReg[rdBank]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRData <= '0;
      busErr   <= 1'b0;
    end else begin
      if (strobes.rdStrobe) regRData <= rdMux;
      busErr <= strobes.anyErr;
    end
  end

  assign eccIrq = |statusFlags;

endmodule

// File: rtl/eccFaultLog.sv
module eccFaultLog
  import eccLogPkg::*;
#(
  parameter int NumBanks = LOG_BANKS,
  parameter int AddrW    = 20,
  parameter int DataW    = 32,
  parameter int RegAW    = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumBanks-1:0]       bankErr,
  input  logic [NumBanks*AddrW-1:0] bankAddr,
  input  logic                      regWrEn,
  input  logic                      regRdEn,
  input  logic [RegAW-1:0]          regAddr,
  input  logic [DataW-1:0]          regWData,
  output logic [DataW-1:0]          regRData,
  output logic                      eccIrq,
  output logic                      busErr
);

  localparam int BankIdxW = (NumBanks > 1) ? $clog2(NumBanks) : 1;

  logStrobes_t               strobes;
  logic [NumBanks-1:0]       statusFlags;
  logic [NumBanks-1:0]       setMask;
  logic [NumBanks-1:0]       clrMask;
  logic [NumBanks-1:0]       loadMask;
  logic [BankIdxW-1:0]       rdBank;
  logic [NumBanks*AddrW-1:0] addrFlat;
  logic                      unusedWrHigh;

  assign unusedWrHigh = ^regWData[DataW-1:NumBanks];

  eccLogCtrl #(
    .NumBanks(NumBanks),
    .RegAW   (RegAW)
  ) u_ctrl (
    .bankErr    (bankErr),
    .statusFlags(statusFlags),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .wrBits     (regWData[NumBanks-1:0]),
    .strobes    (strobes),
    .setMask    (setMask),
    .clrMask    (clrMask),
    .loadMask   (loadMask),
    .rdBank     (rdBank)
  );

  eccLogData #(
    .NumBanks(NumBanks),
    .AddrW   (AddrW),
    .DataW   (DataW)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .setMask    (setMask),
    .clrMask    (clrMask),
    .loadMask   (loadMask),
    .rdBank     (rdBank),
    .bankAddr   (bankAddr),
    .statusFlags(statusFlags),
    .addrFlat   (addrFlat),
    .regRData   (regRData),
    .busErr     (busErr),
    .eccIrq     (eccIrq)
  );

endmodule

// File: rtl/eccFaultLogChk.sv
module eccFaultLogChk #(
  parameter int NumBanks = 8,
  parameter int AddrW    = 20,
  parameter int DataW    = 32,
  parameter int RegAW    = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NumBanks-1:0]       bankErr,
  input logic [NumBanks*AddrW-1:0] bankAddr,
  input logic                      regWrEn,
  input logic [RegAW-1:0]          regAddr,
  input logic [DataW-1:0]          regWData,
  input logic [NumBanks-1:0]       statusFlags,
  input logic [NumBanks*AddrW-1:0] addrFlat,
  input logic                      eccIrq,
  input logic                      busErr
);

  logic [NumBanks-1:0] chkClr;
  logic                unusedChkHigh;

  assign chkClr = (regWrEn && regAddr == '0) ? regWData[NumBanks-1:0] : '0;
  assign unusedChkHigh = ^regWData[DataW-1:NumBanks];

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|bankErr) |=> ((statusFlags & $past(bankErr)) == $past(bankErr)));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusFlags & ~$past(statusFlags) & ~$past(bankErr)) == '0));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusFlags & $past(statusFlags) & ~$past(chkClr))
              == ($past(statusFlags) & ~$past(chkClr))));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusFlags & $past(chkClr) & ~$past(bankErr)) == '0));

  for (genvar g = 0; g < NumBanks; g++) begin : g_chk
    assert_keep_first_R6: assert property (@(posedge clk) disable iff (!rstN)
      (statusFlags[g] && !chkClr[g]) |=> $stable(addrFlat[g*AddrW +: AddrW]));

    assert_collide_R7: assert property (@(posedge clk) disable iff (!rstN)
      (bankErr[g] && chkClr[g]) |=>
        (statusFlags[g] && addrFlat[g*AddrW +: AddrW] == $past(bankAddr[g*AddrW +: AddrW])));

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
      (bankErr[g] && !statusFlags[g]) |=>
        (addrFlat[g*AddrW +: AddrW] == $past(bankAddr[g*AddrW +: AddrW])));
  end

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|bankErr) |=> eccIrq);

  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (((statusFlags & ~chkClr) == '0) && (bankErr == '0)) |=> !eccIrq);

  assert_buserr_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|bankErr) |=> busErr);

  assert_buserr_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bankErr == '0) |=> !busErr);

endmodule

bind eccFaultLog eccFaultLogChk #(
  .NumBanks(NumBanks),
  .AddrW   (AddrW),
  .DataW   (DataW),
  .RegAW   (RegAW)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bankErr    (bankErr),
  .bankAddr   (bankAddr),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWData   (regWData),
  .statusFlags(statusFlags),
  .addrFlat   (addrFlat),
  .eccIrq     (eccIrq),
  .busErr     (busErr)
);

// File: tb/eccFaultLog_bench.sv
`timescale 1ns/1ps
module eccFaultLog_bench;

  localparam int NB = 8;
  localparam int AW = 20;
  localparam int DW = 32;
  localparam int RAW = 4;

  // {error mask, W1C mask, expected flags afterwards}
  localparam int NVEC = 11;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h01_00_01,
    24'h82_00_83,
    24'h00_02_81,
    24'h00_00_81,
    24'h10_81_10,
    24'h10_10_10,
    24'h00_FF_00,
    24'hFF_00_FF,
    24'h0F_00_FF,
    24'h00_0F_F0,
    24'h00_F0_00
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NB-1:0]     bankErr = '0;
  logic [NB*AW-1:0]  bankAddr = '0;
  logic              regWrEn = 1'b0;
  logic              regRdEn = 1'b0;
  logic [RAW-1:0]    regAddr = '0;
  logic [DW-1:0]     regWData = '0;
  logic [DW-1:0]     regRData;
  logic              eccIrq;
  logic              busErr;

  int chkCnt = 0;
  int failCnt = 0;

  logic [NB-1:0] mFlags;
  logic [AW-1:0] mAddr [NB];

  always #2 clk = ~clk;

  eccFaultLog #(.NumBanks(NB), .AddrW(AW), .DataW(DW), .RegAW(RAW)) u_eccFaultLog (
    .clk(clk), .rstN(rstN), .bankErr(bankErr), .bankAddr(bankAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWData(regWData),
    .regRData(regRData), .eccIrq(eccIrq), .busErr(busErr)
  );

  function automatic logic [AW-1:0] seedAddr(input int v, input int b);
    return AW'(32'h40000 | (v << 8) | (b << 4) | 3);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    chkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge with regRData updated
  task automatic readReg(input logic [RAW-1:0] idx, output logic [DW-1:0] val);
    regRdEn = 1'b1;
    regAddr = idx;
    @(posedge clk);
    @(negedge clk);
    regRdEn = 1'b0;
    val = regRData;
  endtask

  // one cycle of errors plus a status write carrying clr
  task automatic errCycle(input logic [NB-1:0] err, input logic [NB-1:0] clr, input int v,
                          input logic [RAW-1:0] wIdx);
    bankErr = err;
    for (int b = 0; b < NB; b++) bankAddr[b*AW +: AW] = seedAddr(v, b);
    regWrEn = 1'b1;
    regAddr = wIdx;
    regWData = DW'(clr);
    if (wIdx == '0) begin
      for (int b = 0; b < NB; b++)
        if (err[b] && (!mFlags[b] || clr[b])) mAddr[b] = seedAddr(v, b);
      mFlags = (mFlags & ~clr) | err;
    end else begin
      for (int b = 0; b < NB; b++)
        if (err[b] && !mFlags[b]) mAddr[b] = seedAddr(v, b);
      mFlags = mFlags | err;
    end
    @(posedge clk);
    @(negedge clk);
    bankErr = '0;
    regWrEn = 1'b0;
    regWData = '0;
  endtask

  task automatic checkAll(input string tag);
    logic [DW-1:0] val;
    readReg('0, val);
    check({tag, " status R2/R3/R4"}, val, DW'(mFlags));
    for (int b = 0; b < NB; b++) begin
      readReg(RAW'(b + 1), val);
      check({tag, " address R5/R6/R7"}, val, DW'(mAddr[b]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  end

  initial begin
    logic [DW-1:0] val;
    mFlags = '0;
    for (int b = 0; b < NB; b++) mAddr[b] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1 irq", DW'(eccIrq), 0);
    check("R1 busErr", DW'(busErr), 0);
    check("R1 rdata", regRData, 0);
    readReg('0, val);
    check("R1 status", val, 0);
    readReg(4'd1, val);
    check("R1 addr bank0", val, 0);
    readReg(4'd8, val);
    check("R1 addr bank7", val, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      errCycle(VEC[v][23:16], VEC[v][15:8], v, '0);
      check($sformatf("R9 vec%0d busErr", v), DW'(busErr), DW'(VEC[v][23:16] != 0));
      check($sformatf("R8 vec%0d irq", v), DW'(eccIrq), DW'(VEC[v][7:0] != 0));
      check($sformatf("R2 vec%0d table flags", v), DW'(mFlags), DW'(VEC[v][7:0]));
      checkAll($sformatf("vec%0d", v));
    end

    // R9: bus error lasts one cycle only
    errCycle(8'h24, 8'h00, 20, '0);
    check("R9 busErr high", DW'(busErr), 1);
    @(posedge clk);
    @(negedge clk);
    check("R9 busErr drops", DW'(busErr), 0);

    // R4: writes to non-status index touch nothing
    errCycle(8'h00, 8'hFF, 21, 4'd3);
    checkAll("R4 other-index write");
    // R4: zero bits in W1C change nothing
    errCycle(8'h00, 8'h00, 22, '0);
    readReg('0, val);
    check("R4 zero write", val, 32'h24);

    // R10: unmapped reads return zero, no read holds data
    readReg(4'd9, val);
    check("R10 unmapped 9", val, 0);
    readReg(4'd15, val);
    check("R10 unmapped 15", val, 0);
    readReg('0, val);
    regAddr = 4'd3;
    @(posedge clk);
    @(negedge clk);
    check("R10 hold", regRData, 32'h24);

    // R8: interrupt falls when last flag clears
    errCycle(8'h00, 8'h04, 23, '0);
    check("R8 irq one flag left", DW'(eccIrq), 1);
    errCycle(8'h00, 8'h20, 24, '0);
    check("R8 irq falls", DW'(eccIrq), 0);

    // R5: recapture after clear uses the new address
    errCycle(8'h20, 8'h00, 25, '0);
    readReg(4'd6, val);
    check("R5 recapture bank5", val, DW'(seedAddr(25, 5)));

    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  end

endmodule